// File: doc/BRIEF.md
# Predicated Saturating MAC Lane

One processing lane of a wide SIMD array for neural workloads. The lane keeps four 16-bit local data registers and one 32-bit signed accumulator. An operation takes one or two operands from the local registers and folds them into the accumulator with a multiply-accumulate, an arithmetic right shift, a minimum or a maximum. A MAC result that goes past the 32-bit range clamps to the nearest limit. It never wraps around to the other sign.

Only the neighbour path loads the data registers. A word arriving from the lane on the left is written into a chosen register. One cycle later the word it displaced leaves on the right-hand output. A row of lanes can therefore pass a vector along, one lane per cycle, as a fully connected layer needs. Each operation names one of eight predicate bits and commits only when that bit is set. Byte operands finish in a single cycle. Full 16-bit operands take three cycles, and the lane reports busy during the extra cycles.

Top module: `mac_lane`

## Requirements
- R1: After reset the accumulator is 0, busy is 0, nbrOutValid is 0, every data register holds 0 and all eight predicate bits are 1.
- R2: When nbrInValid is 1 at a clock edge, nbrInData is written into data register nbrIdx. In the following cycle nbrOutValid is 1 and nbrOutData carries the word that register held before the write. In a cycle after an edge where nbrInValid was 0, nbrOutValid is 0.
- R3: srcA and srcB select the data registers used as operands A and B. In byte mode (opWide=0) only bits 7:0 are used. Each operand is widened to 9 bits: by sign extension when its flag (signA, signB) is 1, and by zero extension when the flag is 0.
- R4: opCode 0 adds A*B to the accumulator. opCode 1 shifts the accumulator arithmetically right by B bits 4:0. opCode 2 keeps the signed minimum of the accumulator and A. opCode 3 keeps the signed maximum.
- R5: A byte-mode operation that is accepted at a clock edge updates the accumulator at that same edge.
- R6: With opWide=1 both operands are the full 16 bits, taken as signed, and the sign flags are ignored. The result appears at the third edge, counting the edge of acceptance as the first. Busy is 1 in the two cycles between those edges.
- R7: An operation presented while busy is 1 is ignored.
- R8: predWrEn writes predWrVal into predicate bit predWrIdx. An operation commits only if predicate bit predSel, sampled when the operation is accepted, is 1. Otherwise the accumulator keeps its value.
- R9: A MAC whose exact sum is above 2^31-1 leaves 32'h7FFFFFFF in the accumulator. A MAC whose exact sum is below -2^31 leaves 32'h80000000.
- R10: accClear zeroes the accumulator at the next edge and takes priority over a commit that falls on the same edge. It does not change the data registers or the predicate bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| accClear | input | 1 | Zero the accumulator |
| opValid | input | 1 | Issue an operation |
| opCode | input | 2 | 0 MAC, 1 shift right, 2 min, 3 max |
| opWide | input | 1 | 1 selects 16-bit signed operands (three cycles) |
| srcA | input | 2 | Register index of operand A |
| srcB | input | 2 | Register index of operand B |
| signA | input | 1 | Byte mode: operand A is signed |
| signB | input | 1 | Byte mode: operand B is signed |
| predSel | input | 3 | Predicate bit that gates the operation |
| predWrEn | input | 1 | Write a predicate bit |
| predWrIdx | input | 3 | Predicate bit to write |
| predWrVal | input | 1 | Value to write into the predicate bit |
| nbrInValid | input | 1 | Word arriving from the neighbouring lane |
| nbrInData | input | 16 | Arriving word |
| nbrIdx | input | 2 | Register the arriving word replaces |
| nbrOutValid | output | 1 | Displaced word is valid |
| nbrOutData | output | 16 | Displaced word, passed to the next lane |
| busy | output | 1 | Wide operation still in flight |
| acc | output | 32 | Accumulator |

## Verification
Two events can land on the same clock edge: the accumulator clear, and the deferred commit of a wide operation. The bench issues a wide MAC and raises accClear two cycles later, so the clear meets the commit edge. It then expects zero rather than the product. It follows with a byte MAC on the same registers, which shows that the clear left the operands alone. A second overlap comes from presenting a byte operation in the middle of a wide one. The accumulator must then show only the wide result.

// File: rtl/mac_lane_pkg.sv
package mac_lane_pkg;
  typedef enum logic [1:0] {
    OP_MAC = 2'd0,
    OP_SHR = 2'd1,
    OP_MIN = 2'd2,
    OP_MAX = 2'd3
  } laneOp_t;

  typedef struct packed {
    logic capture;  // operation accepted this cycle
    logic commit;   // write ALU result into accumulator
    logic clear;    // zero the accumulator
  } laneStrobe_t;
endpackage

// File: rtl/mac_lane_ctrl.sv
module mac_lane_ctrl
  import mac_lane_pkg::*;
#(
  parameter int NPRED    = 8,
  parameter int WIDE_LAT = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     accClear,
  input  logic                     opValid,
  input  logic                     opWide,
  input  logic [$clog2(NPRED)-1:0] predSel,
  input  logic                     predWrEn,
  input  logic [$clog2(NPRED)-1:0] predWrIdx,
  input  logic                     predWrVal,
  output logic                     busy,
  output laneStrobe_t              strobe
);
  localparam int CW = $clog2(WIDE_LAT);

  logic [NPRED-1:0] predReg;
  logic [CW-1:0]    cnt;
  logic             predHeld;
  logic             accept;
  logic             predNow;

  assign accept  = opValid && (cnt == '0);
  assign predNow = predReg[predSel];
  assign busy    = (cnt != '0);

  always_comb begin
    strobe.capture = accept;
    strobe.commit  = (accept && !opWide && predNow) || ((cnt == CW'(1)) && predHeld);
    strobe.clear   = accClear;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      predReg  <= '1;
      cnt      <= '0;
      predHeld <= 1'b0;
    end else begin
      if (predWrEn) predReg[predWrIdx] <= predWrVal;
      if (accept && opWide) begin
        cnt      <= CW'(WIDE_LAT - 1);
        predHeld <= predNow;
      end else if (cnt != '0) begin
        cnt <= cnt - CW'(1);
      end
    end
  end

  // R6: an accepted wide operation holds the lane busy
  assert_wide_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.capture && opWide) |=> busy);

  // R8: predicate writes land in the addressed bit
  assert_pred_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    predWrEn |=> (predReg[$past(predWrIdx)] == $past(predWrVal)));

  // R7: a commit outside acceptance only comes from an in-flight wide op
  assert_late_commit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.commit && !strobe.capture) |-> busy);
endmodule

// File: rtl/mac_lane_dp.sv
module mac_lane_dp
  import mac_lane_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ACC_W  = 32,
  parameter int NREG   = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  laneStrobe_t             strobe,
  input  laneOp_t                 opCode,
  input  logic                    opWide,
  input  logic [$clog2(NREG)-1:0] srcA,
  input  logic [$clog2(NREG)-1:0] srcB,
  input  logic                    signA,
  input  logic                    signB,
  input  logic                    nbrInValid,
  input  logic [DATA_W-1:0]       nbrInData,
  input  logic [$clog2(NREG)-1:0] nbrIdx,
  output logic                    nbrOutValid,
  output logic [DATA_W-1:0]       nbrOutData,
  output logic [ACC_W-1:0]        acc
);
  localparam int NARROW_W = DATA_W / 2;
  localparam int OPD_W    = DATA_W + 1;
  localparam int PROD_W   = 2 * OPD_W;
  localparam int SUM_W    = PROD_W + 1;
  localparam int SH_W     = $clog2(ACC_W);
  localparam logic signed [SUM_W-1:0] SAT_HI = {{(SUM_W-ACC_W+1){1'b0}}, {(ACC_W-1){1'b1}}};
  localparam logic signed [SUM_W-1:0] SAT_LO = {{(SUM_W-ACC_W+1){1'b1}}, {(ACC_W-1){1'b0}}};

  function automatic logic signed [OPD_W-1:0] extendOp(input logic [DATA_W-1:0] raw,
                                                       input logic sgn, input logic wide);
    if (wide) return $signed({raw[DATA_W-1], raw});
    return $signed({{(OPD_W-NARROW_W){sgn & raw[NARROW_W-1]}}, raw[NARROW_W-1:0]});
  endfunction

  logic [DATA_W-1:0]        dataReg [NREG];
  logic signed [OPD_W-1:0]  liveA, liveB, heldA, heldB, opA, opB;
  logic [SH_W-1:0]          liveSh, heldSh, opSh;
  laneOp_t                  heldOp, curOp;
  logic signed [PROD_W-1:0] opAx, opBx, prod;
  logic signed [SUM_W-1:0]  sum;
  logic signed [ACC_W-1:0]  accS, aCmp, result;

  assign liveA  = extendOp(dataReg[srcA], signA, opWide);
  assign liveB  = extendOp(dataReg[srcB], signB, opWide);
  assign liveSh = dataReg[srcB][SH_W-1:0];

  // byte ops resolve in the accept cycle; wide ops use the captured copy
  assign opA   = strobe.capture ? liveA  : heldA;
  assign opB   = strobe.capture ? liveB  : heldB;
  assign opSh  = strobe.capture ? liveSh : heldSh;
  assign curOp = strobe.capture ? opCode : heldOp;

  assign accS = $signed(acc);
  assign opAx = PROD_W'(opA);
  assign opBx = PROD_W'(opB);
  assign prod = opAx * opBx;
  assign sum  = SUM_W'(accS) + SUM_W'(prod);
  assign aCmp = ACC_W'(opA);

  always_comb begin
    unique case (curOp)
      OP_MAC: begin
        if (sum > SAT_HI)      result = ACC_W'(SAT_HI);
        else if (sum < SAT_LO) result = ACC_W'(SAT_LO);
        else                   result = ACC_W'(sum);
      end
      OP_SHR:  result = accS >>> opSh;
      OP_MIN:  result = (aCmp < accS) ? aCmp : accS;
      default: result = (aCmp > accS) ? aCmp : accS;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) dataReg[i] <= '0;
      nbrOutValid <= 1'b0;
      nbrOutData  <= '0;
      heldA  <= '0;
      heldB  <= '0;
      heldSh <= '0;
      heldOp <= OP_MAC;
      acc    <= '0;
    end else begin
      nbrOutValid <= nbrInValid;
      if (nbrInValid) begin
        dataReg[nbrIdx] <= nbrInData;
        nbrOutData      <= dataReg[nbrIdx];
      end
      if (strobe.capture) begin
        heldA  <= liveA;
        heldB  <= liveB;
        heldSh <= liveSh;
        heldOp <= opCode;
      end
      if (strobe.clear)       acc <= '0;
      else if (strobe.commit) acc <= result;
    end
  end

  // R10: clear wins and leaves zero
  assert_clear_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.clear |=> (acc == '0));

  // R8: without a commit or clear the accumulator holds
  assert_acc_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe.commit && !strobe.clear) |=> $stable(acc));

  // R9: adding a non-negative product to a non-negative sum never turns negative
  assert_no_wrap_pos_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.commit && !strobe.clear && curOp == OP_MAC && !acc[ACC_W-1] && !prod[PROD_W-1])
    |=> !acc[ACC_W-1]);

  // R9: adding a negative product to a negative sum never turns positive
  assert_no_wrap_neg_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.commit && !strobe.clear && curOp == OP_MAC && acc[ACC_W-1] && prod[PROD_W-1])
    |=> acc[ACC_W-1]);

  // R2: the arriving word lands in the addressed register
  assert_nbr_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    nbrInValid |=> (dataReg[$past(nbrIdx)] == $past(nbrInData)));
endmodule

// File: rtl/mac_lane.sv
module mac_lane
  import mac_lane_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int ACC_W    = 32,
  parameter int NREG     = 4,
  parameter int NPRED    = 8,
  parameter int WIDE_LAT = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     accClear,
  input  logic                     opValid,
  input  logic [1:0]               opCode,
  input  logic                     opWide,
  input  logic [$clog2(NREG)-1:0]  srcA,
  input  logic [$clog2(NREG)-1:0]  srcB,
  input  logic                     signA,
  input  logic                     signB,
  input  logic [$clog2(NPRED)-1:0] predSel,
  input  logic                     predWrEn,
  input  logic [$clog2(NPRED)-1:0] predWrIdx,
  input  logic                     predWrVal,
  input  logic                     nbrInValid,
  input  logic [DATA_W-1:0]        nbrInData,
  input  logic [$clog2(NREG)-1:0]  nbrIdx,
  output logic                     nbrOutValid,
  output logic [DATA_W-1:0]        nbrOutData,
  output logic                     busy,
  output logic [ACC_W-1:0]         acc
);
  laneStrobe_t strobe;

  mac_lane_ctrl #(.NPRED(NPRED), .WIDE_LAT(WIDE_LAT)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .accClear(accClear), .opValid(opValid), .opWide(opWide),
    .predSel(predSel), .predWrEn(predWrEn), .predWrIdx(predWrIdx), .predWrVal(predWrVal),
    .busy(busy), .strobe(strobe)
  );

  mac_lane_dp #(.DATA_W(DATA_W), .ACC_W(ACC_W), .NREG(NREG)) dp_i (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .opCode(laneOp_t'(opCode)), .opWide(opWide),
    .srcA(srcA), .srcB(srcB), .signA(signA), .signB(signB),
    .nbrInValid(nbrInValid), .nbrInData(nbrInData), .nbrIdx(nbrIdx),
    .nbrOutValid(nbrOutValid), .nbrOutData(nbrOutData), .acc(acc)
  );
endmodule

// File: tb/mac_lane_tb_top.sv
module mac_lane_tb_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, accClear, opValid, opWide, signA, signB;
  logic predWrEn, predWrVal, nbrInValid, nbrOutValid, busy;
  logic [1:0] opCode, srcA, srcB, nbrIdx;
  logic [2:0] predSel, predWrIdx;
  logic [15:0] nbrInData, nbrOutData;
  logic [31:0] acc;

  int errors = 0;
  int checks = 0;

  mac_lane dut_i (
    .clk(clk), .rst_n(rst_n), .accClear(accClear), .opValid(opValid), .opCode(opCode),
    .opWide(opWide), .srcA(srcA), .srcB(srcB), .signA(signA), .signB(signB),
    .predSel(predSel), .predWrEn(predWrEn), .predWrIdx(predWrIdx), .predWrVal(predWrVal),
    .nbrInValid(nbrInValid), .nbrInData(nbrInData), .nbrIdx(nbrIdx),
    .nbrOutValid(nbrOutValid), .nbrOutData(nbrOutData), .busy(busy), .acc(acc)
  );

  // {op[2], wide, a[16], b[16], signA, signB, expected acc[32]}
  localparam int NVEC = 12;
  localparam logic [68:0] VEC [NVEC] = '{
    {2'd0, 1'b0, 16'h0003, 16'h0004, 1'b0, 1'b0, 32'd12},
    {2'd0, 1'b0, 16'h00FF, 16'h0005, 1'b1, 1'b1, 32'd7},
    {2'd0, 1'b0, 16'h00FF, 16'h00FF, 1'b0, 1'b0, 32'd65032},
    {2'd0, 1'b1, 16'h7FFF, 16'h0002, 1'b0, 1'b0, 32'd130566},
    {2'd0, 1'b1, 16'h8000, 16'h0004, 1'b0, 1'b0, 32'hFFFFFE06},
    {2'd3, 1'b0, 16'h0080, 16'h0000, 1'b1, 1'b0, 32'hFFFFFF80},
    {2'd2, 1'b0, 16'h0080, 16'h0000, 1'b0, 1'b0, 32'hFFFFFF80},
    {2'd3, 1'b0, 16'h0064, 16'h0000, 1'b1, 1'b0, 32'd100},
    {2'd1, 1'b0, 16'h0000, 16'h0002, 1'b0, 1'b0, 32'd25},
    {2'd2, 1'b1, 16'hFFF6, 16'h0000, 1'b0, 1'b0, 32'hFFFFFFF6},
    {2'd1, 1'b1, 16'h0000, 16'h0001, 1'b0, 1'b0, 32'hFFFFFFFB},
    {2'd0, 1'b0, 16'h0080, 16'h0080, 1'b1, 1'b1, 32'd16379}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic loadReg(input logic [1:0] idx, input logic [15:0] val);
    nbrInValid = 1'b1; nbrIdx = idx; nbrInData = val;
    @(negedge clk);
    nbrInValid = 1'b0;
  endtask

  task automatic issue(input logic [1:0] op, input logic wide, input logic [1:0] sa,
                       input logic [1:0] sb, input logic ga, input logic gb, input logic [2:0] ps);
    opValid = 1'b1; opCode = op; opWide = wide; srcA = sa; srcB = sb;
    signA = ga; signB = gb; predSel = ps;
    @(negedge clk);
    opValid = 1'b0;
    if (wide) repeat (2) @(negedge clk);
  endtask

  task automatic setPred(input logic [2:0] idx, input logic val);
    predWrEn = 1'b1; predWrIdx = idx; predWrVal = val;
    @(negedge clk);
    predWrEn = 1'b0;
  endtask

  task automatic clearAcc();
    accClear = 1'b1;
    @(negedge clk);
    accClear = 1'b0;
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    rst_n = 1'b0; accClear = 1'b0; opValid = 1'b0; opCode = 2'd0; opWide = 1'b0;
    srcA = 2'd0; srcB = 2'd0; signA = 1'b0; signB = 1'b0; predSel = 3'd0;
    predWrEn = 1'b0; predWrIdx = 3'd0; predWrVal = 1'b0;
    nbrInValid = 1'b0; nbrInData = 16'h0; nbrIdx = 2'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 acc", acc, 32'd0);
    check("R1 busy", {31'd0, busy}, 32'd0);
    check("R1 nbrOutValid", {31'd0, nbrOutValid}, 32'd0);

    // R2 neighbour path, first write shows the reset content
    loadReg(2'd2, 16'h1234);
    check("R2 valid after shift", {31'd0, nbrOutValid}, 32'd1);
    check("R2 displaced reset word", {16'd0, nbrOutData}, 32'd0);
    @(negedge clk);
    check("R2 valid drops", {31'd0, nbrOutValid}, 32'd0);
    loadReg(2'd2, 16'h5678);
    check("R2 displaced word", {16'd0, nbrOutData}, 32'h1234);

    // R3/R4/R5/R6 vector walk, predicate 0 true from reset (R1)
    for (int i = 0; i < NVEC; i++) begin
      automatic logic [68:0] v = VEC[i];
      automatic logic [1:0] ia = 2'(i % 4);
      automatic logic [1:0] ib = 2'((i + 1) % 4);
      loadReg(ia, v[65:50]);
      loadReg(ib, v[49:34]);
      issue(v[68:67], v[66], ia, ib, v[33], v[32], 3'd0);
      check($sformatf("R3/R4/R5/R6 vector %0d", i), acc, v[31:0]);
    end

    // R9 positive saturation
    clearAcc();
    loadReg(2'd0, 16'h7FFF);
    loadReg(2'd1, 16'h7FFF);
    issue(2'd0, 1'b1, 2'd0, 2'd1, 1'b0, 1'b0, 3'd0);
    issue(2'd0, 1'b1, 2'd0, 2'd1, 1'b0, 1'b0, 3'd0);
    check("R9 below limit", acc, 32'h7FFE0002);
    issue(2'd0, 1'b1, 2'd0, 2'd1, 1'b0, 1'b0, 3'd0);
    check("R9 clamp high", acc, 32'h7FFFFFFF);
    issue(2'd0, 1'b1, 2'd0, 2'd1, 1'b0, 1'b0, 3'd0);
    check("R9 stays high", acc, 32'h7FFFFFFF);

    // R9 negative saturation
    clearAcc();
    loadReg(2'd0, 16'h8000);
    issue(2'd0, 1'b1, 2'd0, 2'd1, 1'b0, 1'b0, 3'd0);
    issue(2'd0, 1'b1, 2'd0, 2'd1, 1'b0, 1'b0, 3'd0);
    check("R9 above low limit", acc, 32'h80010000);
    issue(2'd0, 1'b1, 2'd0, 2'd1, 1'b0, 1'b0, 3'd0);
    check("R9 clamp low", acc, 32'h80000000);

    // R8 predication
    clearAcc();
    loadReg(2'd0, 16'h0002);
    loadReg(2'd1, 16'h0003);
    setPred(3'd3, 1'b0);
    issue(2'd0, 1'b0, 2'd0, 2'd1, 1'b0, 1'b0, 3'd3);
    check("R8 byte op masked", acc, 32'd0);
    issue(2'd0, 1'b1, 2'd0, 2'd1, 1'b0, 1'b0, 3'd3);
    check("R8 wide op masked", acc, 32'd0);
    issue(2'd0, 1'b0, 2'd0, 2'd1, 1'b0, 1'b0, 3'd5);
    check("R8 other predicate true", acc, 32'd6);
    setPred(3'd3, 1'b1);
    issue(2'd0, 1'b0, 2'd0, 2'd1, 1'b0, 1'b0, 3'd3);
    check("R8 predicate re-enabled", acc, 32'd12);

    // R6/R7 busy window and ignored op
    clearAcc();
    opValid = 1'b1; opCode = 2'd0; opWide = 1'b1; srcA = 2'd0; srcB = 2'd1; predSel = 3'd0;
    @(negedge clk);
    check("R6 busy cycle 1", {31'd0, busy}, 32'd1);
    opWide = 1'b0;                       // byte op presented while busy
    @(negedge clk);
    check("R6 busy cycle 2", {31'd0, busy}, 32'd1);
    check("R6 no early result", acc, 32'd0);
    opValid = 1'b0;
    @(negedge clk);
    check("R6 busy released", {31'd0, busy}, 32'd0);
    check("R7 op during busy ignored", acc, 32'd6);

    // R10 clear coinciding with wide commit
    opValid = 1'b1; opWide = 1'b1;
    @(negedge clk);
    opValid = 1'b0;
    @(negedge clk);
    accClear = 1'b1;
    @(negedge clk);
    accClear = 1'b0;
    check("R10 clear beats commit", acc, 32'd0);
    issue(2'd0, 1'b0, 2'd0, 2'd1, 1'b0, 1'b0, 3'd3);
    check("R10 registers and predicate kept", acc, 32'd6);

    finishRun();
  end
endmodule